// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block gathers interrupt requests from eleven sources: seven external pins, two timers, two serial channels and a transfer-busy condition that rides on the last external source. It presents one winning request at a time to a small processor core as a 4-bit source index, a 2-bit level and a valid signal. The core takes the request with an acknowledge pulse and ends the handler with a return strobe. The sources are paired into six groups, and each group gets one of four priority levels. The two bits of a group's level sit in two separate priority registers.

Each source has an enable bit and a pending flag. The external pins pass through edge detectors with fixed or programmable polarity. For most sources the flag clears in hardware when the request is acknowledged. The last external source and its transfer-busy companion keep their flags until software clears them. A higher level may preempt a running handler, and the block tracks up to four nested levels. It also keeps a push-button flag and an auto-wake flag. Hardware sets these two flags, and software clears them by writing zero.

Software reaches all state through an 8-bit register port. Writes take effect at the next clock edge. Reads are combinational.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source indices are: 0 ext0, 1 serial1, 2 timer0, 3 ext2, 4 ext1, 5 ext3, 6 timer1, 7 ext4, 8 serial0, 9 ext5, 10 ext6. Source i belongs to group i/2.
- R2: The level of group g is {prioHi[g], prioLo[g]}, where prioLo is at address 4 and prioHi at address 5. Level 3 is the highest, and a pending request at a higher level wins over one at a lower level.
- R3: Bit 6 of prioLo is stored and reads back, but it has no effect on arbitration. Bit 7 of prioLo and bits 7:6 of prioHi read as zero.
- R4: A flag is set by its event whether or not the source is enabled. A source is offered only when its enable bit is 1. Enables live at address 0 (sources 7:0) and address 1 (bits 2:0 for sources 10:8, bit 3 for the transfer enable).
- R5: Acknowledging an offered request for sources 0 to 9 clears that source's flag at the same clock edge.
- R6: The ext6 flag (address 3, bit 2) and the transfer flag (address 3, bit 3) survive an acknowledge and clear only by a software write. Source 10 is offered when its enable is set and either its flag is set or the transfer flag and transfer enable are both set.
- R7: Among pending requests at the same level, the lowest source index wins.
- R8: While handlers are active, a request is offered only when its level is above the highest active level. An acknowledge marks the offered level active.
- R9: A return strobe retires the highest active level.
- R10: At address 7, bit 0 is the push-button flag and bit 1 the auto-wake flag. Each is set by its event strobe, on every event. Writing 0 to a bit clears it, and writing 1 leaves it unchanged.
- R11: ext0, ext1, ext5 and ext6 flag on falling pin edges, and ext4 on rising edges. ext2 and ext3 flag on falling edges when their polarity bit (address 6, bits 0 and 1) is 0, and on rising edges when it is 1.
- R12: All registers reset to zero. Flags for sources 7:0 sit at address 2 and flags for sources 10:8 at address 3, bits 2:0. A write loads the flag bits, and an event in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| extPin | input | 7 | External interrupt pins ext0..ext6 |
| tmr0Evt | input | 1 | Timer 0 event pulse |
| tmr1Evt | input | 1 | Timer 1 event pulse |
| ser0Evt | input | 1 | Serial channel 0 event pulse |
| ser1Evt | input | 1 | Serial channel 1 event pulse |
| xferEvt | input | 1 | Transfer-busy event pulse |
| pbPress | input | 1 | Push-button event pulse |
| autoWake | input | 1 | Auto-wake event pulse |
| vecValid | output | 1 | A request is offered |
| vecIdx | output | 4 | Offered source index |
| vecLevel | output | 2 | Offered request level |
| vecAck | input | 1 | Core takes the offered request |
| retStrobe | input | 1 | Core returns from the current handler |

## Verification
The bench fires several sources in the same cycle, both at one level and at mixed levels, and checks the order of service. A design that polled in the wrong order, or that swapped the two priority register bits, would hand out vectors in a different sequence. It holds a low-level handler, then preempts it, and checks that an equal or middle-level request stays hidden until a return. A design that mishandled nesting would offer that request early or lose a level. It checks that ext6 and transfer-busy requests stay offered after an acknowledge and that polarity changes select the right edge. It also checks that writing 1 to a wake flag does not set it. A design that cleared ext6 flags in hardware, or that wrote wake bits directly, would fail these checks.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_GROUPS = 6;
  localparam int NUM_SRC    = 11;
  localparam int NUM_EXT    = 7;
  localparam int NUM_LVL    = 4;
  localparam int IDX_W      = $clog2(NUM_SRC);
  localparam int LVL_W      = $clog2(NUM_LVL);
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int SRC_STICKY = 10;

  localparam logic [ADDR_W-1:0] A_EN_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] A_EN_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_FLG_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLG_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRIO_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_PRIO_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_POL     = 3'd6;
  localparam logic [ADDR_W-1:0] A_WAKE    = 3'd7;

  // pins inverted ahead of a rising-edge detector (ext0, ext1, ext5, ext6)
  localparam logic [NUM_EXT-1:0] FIXED_INV = 7'b1100011;

  typedef struct packed {
    logic             ackClr;
    logic [IDX_W-1:0] ackIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_prio_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                wrAddr,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [ADDR_W-1:0]                rdAddr,
  output logic [DATA_W-1:0]                rdData,
  input  logic [NUM_EXT-1:0]               extPin,
  input  logic                             tmr0Evt,
  input  logic                             tmr1Evt,
  input  logic                             ser0Evt,
  input  logic                             ser1Evt,
  input  logic                             xferEvt,
  input  logic                             pbPress,
  input  logic                             autoWake,
  input  ctlStrobe_t                       strb,
  output logic [NUM_SRC-1:0]               pendReq,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    srcLevel
);
  logic [NUM_SRC-1:0]    enReg, flagReg, flagNxt, setVec;
  logic                  xferEn, xferFlag, pbFlag, awFlag;
  logic [NUM_GROUPS:0]   prioLo;
  logic [NUM_GROUPS-1:0] prioHi;
  logic [1:0]            polSel;
  logic [NUM_EXT-1:0]    extInt, extPrev, extEdge;

  // polarity stage: pins 2 and 3 programmable, the others fixed
  for (genvar p = 0; p < NUM_EXT; p++) begin : g_pol
    if (p == 2 || p == 3) begin : g_prog
      assign extInt[p] = polSel[p-2] ? extPin[p] : ~extPin[p];
    end else begin : g_fixed
      assign extInt[p] = extPin[p] ^ FIXED_INV[p];
    end
  end
  assign extEdge = extInt & ~extPrev;

  // event-to-source mapping: index = 2*group + slot
  assign setVec = {extEdge[6], extEdge[5], ser0Evt, extEdge[4], tmr1Evt,
                   extEdge[3], extEdge[1], extEdge[2], tmr0Evt, ser1Evt,
                   extEdge[0]};

  always_comb begin
    flagNxt = flagReg;
    if (wrEn && wrAddr == A_FLG_LO) flagNxt[7:0]  = wrData;
    if (wrEn && wrAddr == A_FLG_HI) flagNxt[10:8] = wrData[2:0];
    for (int i = 0; i < NUM_SRC; i++)
      if (strb.ackClr && strb.ackIdx == IDX_W'(i) && i != SRC_STICKY)
        flagNxt[i] = 1'b0;
    flagNxt = flagNxt | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      flagReg  <= '0;
      xferEn   <= 1'b0;
      xferFlag <= 1'b0;
      pbFlag   <= 1'b0;
      awFlag   <= 1'b0;
      prioLo   <= '0;
      prioHi   <= '0;
      polSel   <= '0;
      extPrev  <= '0;
    end else begin
      extPrev <= extInt;
      flagReg <= flagNxt;
      if (wrEn && wrAddr == A_EN_LO) enReg[7:0] <= wrData;
      if (wrEn && wrAddr == A_EN_HI) begin
        enReg[10:8] <= wrData[2:0];
        xferEn      <= wrData[3];
      end
      if (wrEn && wrAddr == A_PRIO_LO) prioLo <= wrData[NUM_GROUPS:0];
      if (wrEn && wrAddr == A_PRIO_HI) prioHi <= wrData[NUM_GROUPS-1:0];
      if (wrEn && wrAddr == A_POL)     polSel <= wrData[1:0];
      xferFlag <= ((wrEn && wrAddr == A_FLG_HI) ? wrData[3] : xferFlag) | xferEvt;
      pbFlag   <= ((wrEn && wrAddr == A_WAKE) ? (pbFlag & wrData[0]) : pbFlag) | pbPress;
      awFlag   <= ((wrEn && wrAddr == A_WAKE) ? (awFlag & wrData[1]) : awFlag) | autoWake;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign srcLevel[s] = {prioHi[s/2], prioLo[s/2]};
    if (s == SRC_STICKY) begin : g_sticky
      assign pendReq[s] = enReg[s] & (flagReg[s] | (xferFlag & xferEn));
    end else begin : g_plain
      assign pendReq[s] = enReg[s] & flagReg[s];
    end
  end

  always_comb begin
    case (rdAddr)
      A_EN_LO:   rdData = enReg[7:0];
      A_EN_HI:   rdData = {4'b0, xferEn, enReg[10:8]};
      A_FLG_LO:  rdData = flagReg[7:0];
      A_FLG_HI:  rdData = {4'b0, xferFlag, flagReg[10:8]};
      A_PRIO_LO: rdData = {1'b0, prioLo};
      A_PRIO_HI: rdData = {2'b0, prioHi};
      A_POL:     rdData = {6'b0, polSel};
      default:   rdData = {6'b0, awFlag, pbFlag};
    endcase
  end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            pendReq,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] srcLevel,
  input  logic                          vecAck,
  input  logic                          retStrobe,
  output logic                          vecValid,
  output logic [IDX_W-1:0]              vecIdx,
  output logic [LVL_W-1:0]              vecLevel,
  output ctlStrobe_t                    strb
);
  logic [NUM_LVL-1:0] activeMask;
  logic [LVL_W-1:0]   curLevel;
  logic               anyActive, found;

  // highest level first, then lowest index within that level
  always_comb begin
    found    = 1'b0;
    vecIdx   = '0;
    vecLevel = '0;
    for (int lvl = NUM_LVL - 1; lvl >= 0; lvl--)
      for (int i = 0; i < NUM_SRC; i++)
        if (!found && pendReq[i] && srcLevel[i] == LVL_W'(lvl)) begin
          found    = 1'b1;
          vecIdx   = IDX_W'(i);
          vecLevel = LVL_W'(lvl);
        end
  end

  always_comb begin
    curLevel = '0;
    for (int lvl = 0; lvl < NUM_LVL; lvl++)
      if (activeMask[lvl]) curLevel = LVL_W'(lvl);
  end
  assign anyActive = |activeMask;

  assign vecValid    = found && (!anyActive || vecLevel > curLevel);
  assign strb.ackClr = vecAck && vecValid;
  assign strb.ackIdx = vecIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeMask <= '0;
    end else begin
      for (int lvl = 0; lvl < NUM_LVL; lvl++) begin
        if (strb.ackClr && vecLevel == LVL_W'(lvl))
          activeMask[lvl] <= 1'b1;
        else if (retStrobe && anyActive && curLevel == LVL_W'(lvl))
          activeMask[lvl] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [7:0]        wrData,
  input  logic [2:0]        rdAddr,
  output logic [7:0]        rdData,
  input  logic [6:0]        extPin,
  input  logic              tmr0Evt,
  input  logic              tmr1Evt,
  input  logic              ser0Evt,
  input  logic              ser1Evt,
  input  logic              xferEvt,
  input  logic              pbPress,
  input  logic              autoWake,
  output logic              vecValid,
  output logic [3:0]        vecIdx,
  output logic [1:0]        vecLevel,
  input  logic              vecAck,
  input  logic              retStrobe
);
  ctlStrobe_t                    strb;
  logic [NUM_SRC-1:0]            pendReq;
  logic [NUM_SRC-1:0][LVL_W-1:0] srcLevel;

  irq_prio_dp u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extPin(extPin),
    .tmr0Evt(tmr0Evt), .tmr1Evt(tmr1Evt), .ser0Evt(ser0Evt), .ser1Evt(ser1Evt),
    .xferEvt(xferEvt), .pbPress(pbPress), .autoWake(autoWake),
    .strb(strb), .pendReq(pendReq), .srcLevel(srcLevel)
  );

  irq_prio_ctl u_ctl (
    .clk(clk), .rstN(rstN), .pendReq(pendReq), .srcLevel(srcLevel),
    .vecAck(vecAck), .retStrobe(retStrobe),
    .vecValid(vecValid), .vecIdx(vecIdx), .vecLevel(vecLevel), .strb(strb)
  );
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               vecValid,
  input logic [IDX_W-1:0]   vecIdx,
  input logic [LVL_W-1:0]   vecLevel,
  input logic               vecAck,
  input logic               retStrobe,
  input logic               pbPress,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [NUM_SRC-1:0] flagReg,
  input logic [NUM_SRC-1:0] setVec,
  input logic [NUM_SRC-1:0] pendReq,
  input logic [NUM_LVL-1:0] activeMask,
  input logic               pbFlag
);
  logic [NUM_SRC-1:0] idxHot;
  logic [NUM_LVL-1:0] lvlHot;
  logic [LVL_W-1:0]   topLvl;
  logic               flagWr, taken;

  assign idxHot = NUM_SRC'(1) << vecIdx;
  assign lvlHot = NUM_LVL'(1) << vecLevel;
  assign flagWr = wrEn && (wrAddr == A_FLG_LO || wrAddr == A_FLG_HI);
  assign taken  = vecAck && vecValid;

  always_comb begin
    topLvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (activeMask[l]) topLvl = LVL_W'(l);
  end

  p_offer_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> |(pendReq & idxHot));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (taken && vecIdx != IDX_W'(SRC_STICKY) && !(|(setVec & idxHot)) && !flagWr)
      |=> ((flagReg & $past(idxHot)) == '0));

  p_sticky_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (taken && vecIdx == IDX_W'(SRC_STICKY) && flagReg[SRC_STICKY] && !flagWr)
      |=> flagReg[SRC_STICKY]);

  p_nest_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && |activeMask) |-> (vecLevel > topLvl));

  p_ack_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    (taken && !retStrobe) |=> |(activeMask & $past(lvlHot)));

  p_ret_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && |activeMask && !taken)
      |=> ($countones(activeMask) == $countones($past(activeMask)) - 1));

  p_pb_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    pbPress |=> pbFlag);
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rstN(rstN), .vecValid(vecValid), .vecIdx(vecIdx),
  .vecLevel(vecLevel), .vecAck(vecAck), .retStrobe(retStrobe),
  .pbPress(pbPress), .wrEn(wrEn), .wrAddr(wrAddr),
  .flagReg(u_dp.flagReg), .setVec(u_dp.setVec), .pendReq(pendReq),
  .activeMask(u_ctl.activeMask), .pbFlag(u_dp.pbFlag)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [6:0] extPin;
  logic [6:0] evt = '0;
  logic       vecValid, vecAck = 1'b0, retStrobe = 1'b0;
  logic [3:0] vecIdx;
  logic [1:0] vecLevel;

  localparam logic [6:0] IDLE = 7'b1101111;
  localparam logic [6:0] E_TMR0 = 7'd1, E_TMR1 = 7'd2, E_SER0 = 7'd4,
                         E_SER1 = 7'd8, E_XFER = 7'd16, E_PB = 7'd32, E_AW = 7'd64;

  always #2 clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extPin(extPin),
    .tmr0Evt(evt[0]), .tmr1Evt(evt[1]), .ser0Evt(evt[2]), .ser1Evt(evt[3]),
    .xferEvt(evt[4]), .pbPress(evt[5]), .autoWake(evt[6]),
    .vecValid(vecValid), .vecIdx(vecIdx), .vecLevel(vecLevel),
    .vecAck(vecAck), .retStrobe(retStrobe)
  );

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  typedef struct { int idx; int lvl; string tag; } expVec_t;
  expVec_t sbQ[$];

  task automatic checkEq(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic regWr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic regChk(logic [2:0] a, int exp, string tag);
    rdAddr = a; #1;
    checkEq(tag, rdData, exp);
  endtask

  task automatic stim(logic [6:0] pins, logic [6:0] ev);
    @(negedge clk); extPin = pins; evt = ev;
    @(negedge clk); evt = '0;
  endtask

  // driver side: push what must come out next
  task automatic expectVec(int idx, int lvl, string tag);
    expVec_t e;
    e.idx = idx; e.lvl = lvl; e.tag = tag;
    sbQ.push_back(e);
  endtask

  // monitor side: pop, compare with the offered vector, acknowledge
  task automatic serviceNext();
    expVec_t e;
    e = sbQ.pop_front();
    checkEq({e.tag, " valid"}, vecValid, 1);
    checkEq({e.tag, " idx"}, vecIdx, e.idx);
    checkEq({e.tag, " level"}, vecLevel, e.lvl);
    vecAck = 1'b1;
    @(negedge clk); vecAck = 1'b0;
  endtask

  task automatic retire();
    retStrobe = 1'b1;
    @(negedge clk); retStrobe = 1'b0;
  endtask

  task automatic expectNone(string tag);
    checkEq({tag, " no vector"}, vecValid, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    extPin = IDLE;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    for (int a = 0; a < 8; a++) regChk(3'(a), 0, "R12 reset reg");
    expectNone("R12 reset");

    // R4 flag sets while disabled, nothing offered
    stim(IDLE, E_TMR0);
    expectNone("R4 disabled source");
    regChk(3'd2, 8'h04, "R4 flag set while disabled");
    regWr(3'd2, 8'h00);
    regChk(3'd2, 8'h00, "R12 software flag clear");
    regWr(3'd0, 8'hFF);
    regWr(3'd1, 8'h0F);

    // R7 same level: timer0 (idx 2) beats ext4 (idx 7); R8 equal level blocked
    stim(IDLE | 7'h10, E_TMR0);
    expectVec(2, 0, "R7 first timer0");
    serviceNext();
    regChk(3'd2, 8'h80, "R5 ack cleared timer0 flag only");
    expectNone("R8 equal level blocked");
    retire();
    expectVec(7, 0, "R7 then ext4 R1");
    serviceNext();
    retire();
    stim(IDLE, '0);
    expectNone("R11 ext4 falling ignored");
    regChk(3'd2, 8'h00, "R11 ext4 falling no flag");

    // R7 within group: ext0 (idx 0) beats serial1 (idx 1)
    stim(IDLE & ~7'h01, E_SER1);
    expectVec(0, 0, "R7 group ext0");
    serviceNext();
    retire();
    expectVec(1, 0, "R7 group serial1");
    serviceNext();
    retire();
    stim(IDLE, '0);
    expectNone("R11 ext0 rising ignored");

    // R3 priority register readback
    regWr(3'd4, 8'h4A);
    regWr(3'd5, 8'hD8);
    regChk(3'd4, 8'h4A, "R3 prioLo readback");
    regChk(3'd5, 8'h18, "R3 prioHi upper bits zero");

    // R2 levels: g3=3, g4=2, g1=1, g0=0
    stim(IDLE & ~7'h01, E_TMR1 | E_SER0 | E_TMR0);
    expectVec(6, 3, "R2 timer1 level3");
    serviceNext(); retire();
    expectVec(8, 2, "R2 serial0 level2");
    serviceNext(); retire();
    expectVec(2, 1, "R2 timer0 level1");
    serviceNext(); retire();
    expectVec(0, 0, "R2 ext0 level0");
    serviceNext(); retire();
    stim(IDLE, '0);

    // R8 preemption and R9 unwinding
    stim(IDLE & ~7'h01, '0);
    expectVec(0, 0, "R8 base handler");
    serviceNext();
    stim(IDLE, E_TMR1);
    expectVec(6, 3, "R8 preempt level3");
    serviceNext();
    stim(IDLE, E_SER0);
    expectNone("R8 level2 under level3");
    retire();
    expectVec(8, 2, "R9 pop reveals level2");
    serviceNext();
    retire();
    expectNone("R9 level0 still active");
    retire();
    expectNone("R9 all retired");
    regWr(3'd4, 8'h00);
    regWr(3'd5, 8'h00);

    // R11 edge polarity
    stim(IDLE & ~7'h04, '0);
    regChk(3'd2, 8'h08, "R11 ext2 falling pol0");
    regWr(3'd2, 8'h00);
    stim(IDLE, '0);
    regChk(3'd2, 8'h00, "R11 ext2 rising ignored pol0");
    stim(IDLE & ~7'h04, '0);
    regWr(3'd2, 8'h00);
    regWr(3'd6, 8'h01);
    stim(IDLE, '0);
    regChk(3'd2, 8'h08, "R11 ext2 rising pol1");
    regWr(3'd2, 8'h00);
    stim(IDLE & ~7'h04, '0);
    regChk(3'd2, 8'h00, "R11 ext2 falling ignored pol1");
    stim(IDLE, '0);
    regWr(3'd6, 8'h00);
    regWr(3'd2, 8'h00);
    regChk(3'd2, 8'h00, "R11 ext2 restore");
    stim(IDLE & ~7'h20, '0);
    regChk(3'd3, 8'h02, "R11 ext5 falling pin");
    regWr(3'd3, 8'h00);
    stim(IDLE, '0);
    regChk(3'd3, 8'h00, "R11 ext5 rising ignored");
    stim(IDLE & ~7'h02, '0);
    regChk(3'd2, 8'h10, "R11 ext1 falling");
    regWr(3'd2, 8'h00);
    stim(IDLE, '0);

    // R6 sticky ext6 and transfer flags
    stim(IDLE & ~7'h40, '0);
    expectVec(10, 0, "R6 ext6 first");
    serviceNext(); retire();
    expectVec(10, 0, "R6 ext6 still pending");
    serviceNext(); retire();
    regChk(3'd3, 8'h04, "R6 ext6 flag kept");
    stim(IDLE, '0);
    regWr(3'd3, 8'h00);
    expectNone("R6 ext6 cleared by write");
    stim(IDLE, E_XFER);
    expectVec(10, 0, "R6 transfer request");
    serviceNext(); retire();
    regChk(3'd3, 8'h08, "R6 transfer flag kept");
    regWr(3'd3, 8'h00);
    expectNone("R6 transfer cleared");
    regWr(3'd1, 8'h07);
    stim(IDLE, E_XFER);
    expectNone("R6 transfer enable off");
    regChk(3'd3, 8'h08, "R6 transfer flag set anyway");
    regWr(3'd3, 8'h00);

    // R10 wake flags
    stim(IDLE, E_PB);
    regChk(3'd7, 8'h01, "R10 push button set");
    stim(IDLE, E_PB);
    regChk(3'd7, 8'h01, "R10 second press");
    regWr(3'd7, 8'h02);
    regChk(3'd7, 8'h00, "R10 write0 clears write1 no set");
    stim(IDLE, E_AW);
    regChk(3'd7, 8'h02, "R10 auto wake set");
    regWr(3'd7, 8'h01);
    regChk(3'd7, 8'h00, "R10 auto wake cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule